// File: doc/BRIEF.md
# UART Framer with Break and Parity

This block serialises parallel words onto a transmit line and rebuilds parallel words from a receive line. It is paced by one `bit_tick` pulse per bit period, supplied by an external baud generator. The receiver samples the line once on each tick, with no oversampling. Words can be 7, 8 or 9 bits wide. An odd or even parity bit is added and checked only in normal mode, and only with 7-bit or 8-bit words.

Software can hold the transmit line low as a break. The receiver reports a break only after a frame has ended with a low stop bit and the line has then stayed low for a set number of bit periods.

A loopback mode routes the transmit output back into the receiver. An attention mode runs frames without parity. The receiver output is a one-cycle valid strobe. Along with it come the word and the parity and framing error flags for that frame.

Top module: `uart_framer`

## Requirements
- R1: A frame goes out least significant bit first: one low start bit, the data bits, the parity bit if one is active, then one high stop bit. One bit is sent per `bit_tick`, and the first bit appears on the tick after `tx_load`. `tx_busy` stays high until the stop bit has been driven. A `tx_load` while `tx_busy` is high is ignored, and the idle line is high.
- R2: `fmt` sets the word width: 2'b00 is 7 bits, 2'b10 is 9 bits, and 2'b01 or 2'b11 is 8 bits. Transmit data bits above the width are not sent. Received words are zero-extended in `rx_data`.
- R3: A parity bit is active only when `par_en`=1 and `par_sel` is 2'b01 (odd) or 2'b10 (even). With odd parity the data bits plus the parity bit hold an odd number of ones; with even parity they hold an even number.
- R4: No parity bit is sent or expected with 9-bit words, in loopback (`mode`=2'b01), in attention (`mode`=2'b10), or when `par_sel` is 2'b00 or 2'b11, whatever `par_en` is. `par_err` then stays low.
- R5: A low sample on a tick while the receiver is idle starts a frame. `rx_valid` pulses for one clock cycle right after the tick that samples the stop bit, and `rx_data` carries the word from then on.
- R6: When the received parity bit does not match the word, `par_err` is high together with that frame's `rx_valid`. It is low for a frame whose parity matches.
- R7: A low stop-bit sample gives `frm_err`=1 with `rx_valid`. The receiver then starts no new frame until it has sampled the line high.
- R8: After a low stop bit, `brk_det` is set on the 10th consecutive low tick following the stop-bit tick (`BRK_BITS`=10). A high sample restarts the count, and only a further low stop bit starts it again.
- R9: `brk_det` stays set until `brk_clr` is pulsed while the receive line is high. A `brk_clr` pulse while the line is low has no effect.
- R10: While `brk_send` is high, `txd` is low from the next clock cycle onward. `txd` returns to the transmitter level one cycle after `brk_send` falls.
- R11: In loopback the receiver reads `txd` and ignores `rx_pin`. A transmitted frame is therefore received one tick after its stop bit is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One pulse per bit period |
| tx_data | input | 9 | Word to transmit |
| tx_load | input | 1 | Start a transmit frame |
| tx_busy | output | 1 | Transmitter is sending a frame |
| txd | output | 1 | Serial transmit line |
| rx_pin | input | 1 | Serial receive line |
| fmt | input | 2 | Word width select |
| par_en | input | 1 | Parity enable |
| par_sel | input | 2 | Parity type select |
| brk_send | input | 1 | Hold the transmit line low |
| mode | input | 2 | 00 normal, 01 loopback, 10 attention |
| brk_clr | input | 1 | Clear the break flag |
| rx_data | output | 9 | Last received word |
| rx_valid | output | 1 | One-cycle strobe when a frame ends |
| par_err | output | 1 | Parity mismatch in the last frame |
| frm_err | output | 1 | Low stop bit in the last frame |
| brk_det | output | 1 | Line break detected |

## Verification
Each transmit bit is on `txd` in the clock cycle that follows its tick. The bench issues each tick as a single-cycle pulse and reads `txd` at the next falling edge. Receive results and flags appear in the cycle after the stop-bit tick, so they are read at the falling edge right after that tick, while `rx_valid` is still high. In loopback one extra tick is issued, because the receiver samples each transmitted bit one tick late. The break flag is checked after the 9th and the 10th low tick. The effects of `brk_send` and `brk_clr` are read one falling edge after the input changes.

// File: rtl/uart_framer.sv
module uart_framer #(
  parameter int BRK_BITS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic [8:0] tx_data,
  input  logic       tx_load,
  output logic       tx_busy,
  output logic       txd,
  input  logic       rx_pin,
  input  logic [1:0] fmt,
  input  logic       par_en,
  input  logic [1:0] par_sel,
  input  logic       brk_send,
  input  logic [1:0] mode,
  input  logic       brk_clr,
  output logic [8:0] rx_data,
  output logic       rx_valid,
  output logic       par_err,
  output logic       frm_err,
  output logic       brk_det
);
  localparam int CW = $clog2(BRK_BITS + 1);

  function automatic logic [3:0] width_of(input logic [1:0] f);
    case (f)
      2'b00:   return 4'd7;
      2'b10:   return 4'd9;
      default: return 4'd8;
    endcase
  endfunction

  wire [3:0] cfg_n  = width_of(fmt);
  wire       cfg_pa = par_en && (par_sel == 2'b01 || par_sel == 2'b10) &&
                      fmt != 2'b10 && mode == 2'b00;
  wire       cfg_odd = (par_sel == 2'b01);

  // transmitter
  logic [10:0] tx_sh;
  logic [3:0]  tx_cnt;
  logic        tx_line, brk_q;
  logic [10:0] tx_frame;

  wire [8:0] tx_dm = tx_data & ((9'd1 << cfg_n) - 9'd1);
  wire       tx_pb = ^tx_dm ^ cfg_odd;
  wire [3:0] tx_len = cfg_n + 4'd2 + {3'b0, cfg_pa};

  always_comb begin
    tx_frame = {1'b0, tx_dm, 1'b0};
    if (cfg_pa) tx_frame = tx_frame | (11'(tx_pb) << (cfg_n + 4'd1));
    tx_frame = tx_frame | (11'd1 << (cfg_n + 4'd1 + {3'b0, cfg_pa}));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0; tx_cnt <= '0; tx_line <= 1'b1; brk_q <= 1'b0;
    end else begin
      brk_q <= brk_send;
      if (tx_load && tx_cnt == 4'd0) begin
        tx_sh  <= tx_frame;
        tx_cnt <= tx_len;
      end else if (bit_tick && tx_cnt != 4'd0) begin
        tx_line <= tx_sh[0];
        tx_sh   <= tx_sh >> 1;
        tx_cnt  <= tx_cnt - 4'd1;
      end
    end
  end

  assign tx_busy = (tx_cnt != 4'd0);
  assign txd     = tx_line & ~brk_q;

  // receiver
  typedef enum logic [2:0] {RX_IDLE, RX_DATA, RX_PAR, RX_STOP, RX_HOLD} rx_st_t;
  rx_st_t      rx_st;
  logic [3:0]  rx_idx, rx_n;
  logic        rx_pa, rx_odd, rx_pbit;
  logic [8:0]  rx_buf;
  logic [CW-1:0] brk_cnt;

  wire rx_in = (mode == 2'b01) ? txd : rx_pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_st <= RX_IDLE; rx_idx <= '0; rx_n <= 4'd8; rx_pa <= 1'b0;
      rx_odd <= 1'b0; rx_pbit <= 1'b0; rx_buf <= '0; brk_cnt <= '0;
      rx_data <= '0; rx_valid <= 1'b0; par_err <= 1'b0; frm_err <= 1'b0;
      brk_det <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (brk_clr && rx_in) brk_det <= 1'b0;
      if (bit_tick) begin
        case (rx_st)
          RX_IDLE: if (!rx_in) begin
            rx_st <= RX_DATA; rx_idx <= '0; rx_buf <= '0;
            rx_n <= cfg_n; rx_pa <= cfg_pa; rx_odd <= cfg_odd;
          end
          RX_DATA: begin
            rx_buf <= rx_buf | (9'(rx_in) << rx_idx);
            rx_idx <= rx_idx + 4'd1;
            if (rx_idx == rx_n - 4'd1) rx_st <= rx_pa ? RX_PAR : RX_STOP;
          end
          RX_PAR: begin
            rx_pbit <= rx_in;
            rx_st   <= RX_STOP;
          end
          RX_STOP: begin
            rx_valid <= 1'b1;
            rx_data  <= rx_buf;
            par_err  <= rx_pa && (rx_pbit != (^rx_buf ^ rx_odd));
            frm_err  <= !rx_in;
            brk_cnt  <= '0;
            rx_st    <= rx_in ? RX_IDLE : RX_HOLD;
          end
          default: begin
            if (rx_in) begin
              rx_st   <= RX_IDLE;
              brk_cnt <= '0;
            end else if (brk_cnt != CW'(BRK_BITS)) begin
              brk_cnt <= brk_cnt + 1'b1;
              if (brk_cnt == CW'(BRK_BITS - 1)) brk_det <= 1'b1;
            end
          end
        endcase
      end
    end
  end

  AST_BRK_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    brk_send |=> !txd); // R10
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy && !bit_tick |=> tx_busy); // R1
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R5
  AST_NO_PAR_NINE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_n == 4'd9 |-> !par_err); // R4
  AST_BRK_NEEDS_FE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_det) |-> frm_err); // R8
  AST_BRK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    brk_det && !rx_in |=> brk_det); // R9
endmodule

// File: tb/uart_framer_tb.sv
`timescale 1ns/1ps
module uart_framer_tb_top;
  logic clk = 0, rst_n = 0, bit_tick = 0, tx_load = 0, rx_pin = 1;
  logic [8:0] tx_data = '0;
  logic [1:0] fmt = 2'b01, par_sel = 2'b00, mode = 2'b00;
  logic par_en = 0, brk_send = 0, brk_clr = 0;
  logic tx_busy, txd, rx_valid, par_err, frm_err, brk_det;
  logic [8:0] rx_data;
  int total = 0, fails = 0;
  bit done = 0;

  uart_framer dut_i (.clk, .rst_n, .bit_tick, .tx_data, .tx_load, .tx_busy, .txd,
    .rx_pin, .fmt, .par_en, .par_sel, .brk_send, .mode, .brk_clr, .rx_data,
    .rx_valid, .par_err, .frm_err, .brk_det);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    bit_tick = 1; @(negedge clk); bit_tick = 0;
  endtask

  function automatic int n_of(input logic [1:0] f);
    return (f == 2'b00) ? 7 : (f == 2'b10) ? 9 : 8;
  endfunction

  function automatic bit pa_of(input logic [1:0] f, input bit pe, input logic [1:0] ps,
                               input logic [1:0] m);
    return pe && (ps == 2'b01 || ps == 2'b10) && f != 2'b10 && m == 2'b00;
  endfunction

  // builds the expected bit sequence; returns length
  function automatic int build(input logic [8:0] d, input int n, input bit pa, input bit odd,
                               output logic [10:0] fr);
    int ones = 0;
    int k;
    fr = '0;
    for (int i = 0; i < n; i++) begin fr[1+i] = d[i]; ones += d[i]; end
    k = 1 + n;
    if (pa) begin fr[k] = (ones % 2 == 1) ^ odd; k++; end
    fr[k] = 1'b1;
    return k + 1;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [8:0] dv [3] = '{9'h155, 9'h0B3, 9'h1FF};
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    chk(txd == 1 && !tx_busy && !rx_valid && !brk_det, "reset", {txd, tx_busy, rx_valid, brk_det}, 4'b1000);

    // TX sweep: R1 R2 R3 R4
    for (int f = 0; f < 3; f++) for (int pe = 0; pe < 2; pe++)
    for (int ps = 0; ps < 4; ps++) for (int m = 0; m < 3; m++) for (int di = 0; di < 3; di++) begin
      logic [10:0] fr, got;
      int len;
      fmt = 2'(f); par_en = pe[0]; par_sel = 2'(ps); mode = 2'(m); tx_data = dv[di];
      rx_pin = 1;
      len = build(dv[di], n_of(fmt), pa_of(fmt, par_en, par_sel, mode), ps == 1, fr);
      tx_load = 1; @(negedge clk); tx_load = 0;
      got = '0;
      for (int b = 0; b < len; b++) begin
        if (b == 3) begin tx_data = ~dv[di]; tx_load = 1; end
        tick(); tx_load = 0;
        got[b] = txd;
      end
      chk(got == fr, "R1 R2 R3 R4 tx frame", got, fr);
      chk(!tx_busy && txd, "R1 idle after stop", {tx_busy, txd}, 2'b01);
      tick();
    end

    // RX sweep normal and attention: R5 R6 R7 R2 R3 R4
    for (int f = 0; f < 3; f++) for (int pe = 0; pe < 2; pe++)
    for (int ps = 0; ps < 3; ps++) for (int m = 0; m < 3; m += 2)
    for (int di = 0; di < 3; di++) for (int e = 0; e < 3; e++) begin
      logic [10:0] fr;
      int len;
      bit pa;
      logic [8:0] expd;
      fmt = 2'(f); par_en = pe[0]; par_sel = 2'(ps); mode = 2'(m);
      pa = pa_of(fmt, par_en, par_sel, mode);
      if (e == 1 && !pa) continue;
      len = build(dv[di], n_of(fmt), pa, ps == 1, fr);
      if (e == 1) fr[len-2] = ~fr[len-2];
      if (e == 2) fr[len-1] = 1'b0;
      expd = dv[di] & 9'((1 << n_of(fmt)) - 1);
      for (int b = 0; b < len; b++) begin rx_pin = fr[b]; tick(); end
      chk(rx_valid && rx_data == expd, "R5 R2 rx data", rx_data, expd);
      chk(par_err == (e == 1), "R6 R4 par_err", par_err, e == 1);
      chk(frm_err == (e == 2), "R7 frm_err", frm_err, e == 2);
      rx_pin = 1; tick(); tick();
    end

    // R7: no new frame while line stays low after a bad stop bit
    fmt = 2'b01; par_en = 0; mode = 2'b00;
    rx_pin = 0;
    for (int b = 0; b < 10; b++) tick();
    begin
      int seen = 0;
      for (int b = 0; b < 9; b++) begin tick(); seen += rx_valid; end
      chk(seen == 0 && !brk_det, "R7 R8 hold low, no frame", seen, 0);
    end
    tick();
    chk(brk_det, "R8 break on 10th low tick", brk_det, 1);
    brk_clr = 1; @(negedge clk); brk_clr = 0;
    chk(brk_det, "R9 clear ignored while low", brk_det, 1);
    rx_pin = 1; tick();
    chk(brk_det, "R9 stays set when high without clear", brk_det, 1);
    brk_clr = 1; @(negedge clk); brk_clr = 0;
    chk(!brk_det, "R9 clear while high", brk_det, 0);

    // R8: high sample restarts count
    rx_pin = 0; for (int b = 0; b < 10; b++) tick();
    for (int b = 0; b < 5; b++) tick();
    rx_pin = 1; tick(); tick();
    rx_pin = 0; for (int b = 0; b < 12; b++) tick();
    chk(!brk_det, "R8 count restarts after high", brk_det, 0);
    rx_pin = 1; tick(); brk_clr = 1; @(negedge clk); brk_clr = 0;

    // R10 break send
    brk_send = 1; @(negedge clk);
    chk(!txd, "R10 txd low next cycle", txd, 0);
    tick(); tick(); tick();
    chk(!txd, "R10 txd held low", txd, 0);
    brk_send = 0; @(negedge clk);
    chk(txd, "R10 txd released", txd, 1);

    // R11 loopback sweep, rx_pin held low
    for (int f = 0; f < 3; f++) for (int di = 0; di < 3; di++) begin
      logic [10:0] fr;
      int len;
      logic [8:0] expd;
      fmt = 2'(f); par_en = 1; par_sel = 2'b01; mode = 2'b01; rx_pin = 0;
      tx_data = dv[di];
      len = build(dv[di], n_of(fmt), 0, 0, fr);
      expd = dv[di] & 9'((1 << n_of(fmt)) - 1);
      tx_load = 1; @(negedge clk); tx_load = 0;
      for (int b = 0; b < len; b++) tick();
      chk(!rx_valid, "R11 not yet received", rx_valid, 0);
      tick();
      chk(rx_valid && rx_data == expd && !par_err && !frm_err, "R11 R4 loopback", rx_data, expd);
      tick();
    end
    mode = 2'b00; rx_pin = 1; tick();

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule